// File: doc/BRIEF.md
# Multi-Lane Counter-Mode Keystream Scheduler

This block keeps a keystream queue full for a counter-mode stream cipher. Its source is a bank of parallel block-cipher lanes that sit outside the block. A session begins with a start pulse that carries a 128-bit seed counter. The scheduler then launches every lane at once, each on its own counter value. It collects each lane's finished 128-bit output and pushes the outputs into an internal keystream FIFO. Within a round, the outputs enter the FIFO in ascending lane order, so the words in the queue follow the counter sequence one for one.

The first round pre-fills the queue with one word per lane and raises a primed indication. A consumer then pops words from the head of the queue, for example to XOR them with data. A later round is launched only after reads have freed room for a full round, so the lanes restart on demand and never free-run. Pulsing clear ends the session: the queue is discarded and the block waits for the next seed.

The control is a four-state machine:
- IDLE waits for a session start.
- LAUNCH is the one cycle that strobes all lanes.
- COLLECT gathers lane results and writes them to the queue.
- HOLD waits for free space.

Its transitions are:
- BEGIN: IDLE to LAUNCH on start_i.
- FIRE: LAUNCH to COLLECT, always, after one cycle.
- FILLED: COLLECT to HOLD once the last lane's word is written.
- REFILL: HOLD to LAUNCH when the free space is at least the lane count.
- ABORT: any state to IDLE on clear_i.

Top module: `ctr_keystream_sched`

## Requirements
- R1: After reset, lane_start_o is all zero, ks_valid_o is 0 and primed_o is 0.
- R2: A start_i pulse in IDLE loads seed_i as the base counter. In the first strobe cycle, lane k (numbered 1..LANES, start bit k-1, counter slice bits [128k-1:128(k-1)]) is handed seed + (k-1) modulo 2^128.
- R3: Every strobe drives all LANES bits of lane_start_o high for exactly one cycle and is never followed by a strobe in the next cycle.
- R4: The lane-1 counter of each later strobe in a session is the previous strobe's lane-1 counter plus LANES, modulo 2^128.
- R5: Lane results enter the queue in lane order 1..LANES whatever order the done flags arrive in. Reads therefore return the lane output for seed+0, seed+1, seed+2 and so on, in that sequence.
- R6: primed_o rises once the first LANES words of a session are queued. At that point ks_valid_o is 1, and primed_o stays high until clear_i.
- R7: A round is launched only when the queue holds at most DEPTH-LANES words. With the default DEPTH of 32 and no reads, exactly one round runs after start.
- R8: ks_data_o shows the queue head whenever ks_valid_o is 1. A read strobe while ks_valid_o is 0 has no effect on the queue.
- R9: clear_i empties the queue, drops primed_o and returns to IDLE. Done flags arriving later from lanes already running add nothing to the queue, and the next start uses its new seed.
- R10: start_i is ignored while a session is active, so the queue order stays that of the first seed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Session start pulse, seed sampled with it |
| seed_i | input | 128 | Seed counter |
| clear_i | input | 1 | End of session: flush queue, back to idle |
| lane_start_o | output | LANES | Per-lane start strobe, bit k-1 for lane k |
| lane_ctr_o | output | LANES*128 | Per-lane counter, valid during the strobe |
| lane_done_i | input | LANES | Per-lane done pulse |
| lane_data_i | input | LANES*128 | Per-lane result, valid with done |
| ks_rd_i | input | 1 | Pop the queue head |
| ks_data_o | output | 128 | Queue head word |
| ks_valid_o | output | 1 | Queue not empty |
| primed_o | output | 1 | First round fully queued |

## Verification
A wrong base counter or lane offset shows up in the strobe cycle itself as a counter slice that does not match the seed arithmetic. It also shows up at the first read after priming as a keystream word that does not match its counter position. A broken write order or a lost capture appears within the first LANES reads as an out-of-sequence word. A wrong free-space condition shows up as extra strobes while no reads occur, or as a read stream that stalls for good. Leftover state after clear appears at the first read of the next session, as stale data or as a word taken from the old counter sequence.

// File: rtl/ksched_pkg.sv
package ksched_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_LAUNCH  = 2'd1,
        ST_COLLECT = 2'd2,
        ST_HOLD    = 2'd3
    } ks_state_e;

endpackage

// File: rtl/ksched_ctr_gen.sv
// Per-lane counter offsets: lane index k (0-based) gets base + k.
module ksched_ctr_gen #(
    parameter int LANES = 26,
    parameter int W     = 128
) (
    input  logic [W-1:0]       base_i,
    output logic [LANES*W-1:0] ctr_o
);
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign ctr_o[k*W +: W] = base_i + W'(k);
    end
endmodule

// File: rtl/ksched_capture.sv
// Holds each lane's result from its done pulse until the writer takes it.
module ksched_capture #(
    parameter int LANES = 26,
    parameter int W     = 128,
    parameter int IDXW  = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr_i,
    input  logic               arm_i,
    input  logic [LANES-1:0]   done_i,
    input  logic [LANES*W-1:0] data_i,
    input  logic [IDXW-1:0]    sel_i,
    input  logic               take_i,
    output logic               sel_valid_o,
    output logic [W-1:0]       sel_data_o
);
    logic [LANES-1:0] got_q;
    logic [W-1:0]     cap_q [LANES];

    for (genvar k = 0; k < LANES; k++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                got_q[k] <= 1'b0;
            end else if (clr_i) begin
                got_q[k] <= 1'b0;
            end else if (take_i && (sel_i == IDXW'(k))) begin
                got_q[k] <= 1'b0;
            end else if (arm_i && done_i[k] && !got_q[k]) begin
                got_q[k] <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (arm_i && done_i[k] && !got_q[k]) begin
                cap_q[k] <= data_i[k*W +: W];
            end
        end
    end

    always_comb begin
        sel_valid_o = 1'b0;
        sel_data_o  = '0;
        if (int'(sel_i) < LANES) begin
            sel_valid_o = got_q[sel_i];
            sel_data_o  = cap_q[sel_i];
        end
    end
endmodule

// File: rtl/ksched_fifo.sv
// Synchronous keystream queue with flush; DEPTH must be a power of two.
module ksched_fifo #(
    parameter int W     = 128,
    parameter int DEPTH = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       flush_i,
    input  logic                       wr_i,
    input  logic [W-1:0]               wr_data_i,
    input  logic                       rd_i,
    output logic [W-1:0]               rd_data_o,
    output logic                       empty_o,
    output logic                       full_o,
    output logic [$clog2(DEPTH):0]     count_o
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp_q, rp_q;
    logic [AW:0]   cnt_q;
    logic          do_wr, do_rd;

    assign empty_o   = (cnt_q == '0);
    assign full_o    = (cnt_q == (AW+1)'(DEPTH));
    assign count_o   = cnt_q;
    assign rd_data_o = mem[rp_q];
    assign do_wr     = wr_i && !full_o && !flush_i;
    assign do_rd     = rd_i && !empty_o && !flush_i;

    always_ff @(posedge clk) begin
        if (do_wr) begin
            mem[wp_q] <= wr_data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else if (flush_i) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_wr) wp_q <= wp_q + 1'b1;
            if (do_rd) rp_q <= rp_q + 1'b1;
            case ({do_wr, do_rd})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end
endmodule

// File: rtl/ctr_keystream_sched.sv
module ctr_keystream_sched #(
    parameter int LANES = 26,
    parameter int W     = 128,
    parameter int DEPTH = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [W-1:0]       seed_i,
    input  logic               clear_i,
    output logic [LANES-1:0]   lane_start_o,
    output logic [LANES*W-1:0] lane_ctr_o,
    input  logic [LANES-1:0]   lane_done_i,
    input  logic [LANES*W-1:0] lane_data_i,
    input  logic               ks_rd_i,
    output logic [W-1:0]       ks_data_o,
    output logic               ks_valid_o,
    output logic               primed_o
);
    import ksched_pkg::*;

    localparam int IDXW   = $clog2(LANES);
    localparam int CW     = $clog2(DEPTH) + 1;
    localparam int THRESH = DEPTH - LANES;

    ks_state_e        state_q, state_d;
    logic [W-1:0]     base_q;
    logic [IDXW-1:0]  wr_lane_q;
    logic             primed_q;

    logic             arm, take, last_take;
    logic             sel_valid;
    logic [W-1:0]     sel_data;
    logic             fifo_empty, fifo_full;
    logic [CW-1:0]    fifo_count;
    logic             room_ok;

    assign room_ok   = (fifo_count <= CW'(THRESH));
    assign last_take = take && (wr_lane_q == IDXW'(LANES - 1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start_i)   state_d = ST_LAUNCH;   // BEGIN
            ST_LAUNCH:                 state_d = ST_COLLECT;  // FIRE
            ST_COLLECT: if (last_take) state_d = ST_HOLD;     // FILLED
            ST_HOLD:    if (room_ok)   state_d = ST_LAUNCH;   // REFILL
        endcase
        if (clear_i) state_d = ST_IDLE;                       // ABORT
    end

    // outputs
    always_comb begin
        lane_start_o = '0;
        arm          = 1'b0;
        take         = 1'b0;
        unique case (state_q)
            ST_IDLE:    ;
            ST_LAUNCH:  lane_start_o = '1;
            ST_COLLECT: begin
                arm  = 1'b1;
                take = sel_valid && !fifo_full && !clear_i;
            end
            ST_HOLD:    ;
        endcase
    end

    // base counter, write pointer over lanes, primed flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q    <= '0;
            wr_lane_q <= '0;
            primed_q  <= 1'b0;
        end else if (clear_i) begin
            wr_lane_q <= '0;
            primed_q  <= 1'b0;
        end else begin
            if (state_q == ST_IDLE && start_i) begin
                base_q <= seed_i;
            end
            if (state_q == ST_LAUNCH) begin
                base_q    <= base_q + W'(LANES);
                wr_lane_q <= '0;
            end else if (take) begin
                wr_lane_q <= last_take ? '0 : wr_lane_q + 1'b1;
            end
            if (last_take) begin
                primed_q <= 1'b1;
            end
        end
    end

    assign primed_o   = primed_q;
    assign ks_valid_o = !fifo_empty;

    ksched_ctr_gen #(.LANES(LANES), .W(W)) u_ctr (
        .base_i (base_q),
        .ctr_o  (lane_ctr_o)
    );

    ksched_capture #(.LANES(LANES), .W(W), .IDXW(IDXW)) u_cap (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_i       (clear_i),
        .arm_i       (arm),
        .done_i      (lane_done_i),
        .data_i      (lane_data_i),
        .sel_i       (wr_lane_q),
        .take_i      (take),
        .sel_valid_o (sel_valid),
        .sel_data_o  (sel_data)
    );

    ksched_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush_i   (clear_i),
        .wr_i      (take),
        .wr_data_i (sel_data),
        .rd_i      (ks_rd_i),
        .rd_data_o (ks_data_o),
        .empty_o   (fifo_empty),
        .full_o    (fifo_full),
        .count_o   (fifo_count)
    );
endmodule

// File: rtl/ksched_chk.sv
module ksched_chk #(
    parameter int LANES = 26,
    parameter int W     = 128,
    parameter int DEPTH = 32
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   clear_i,
    input logic [LANES-1:0]       lane_start_o,
    input logic [W-1:0]           ctr0,
    input logic                   ks_valid_o,
    input logic                   primed_o,
    input logic [$clog2(DEPTH):0] occ
);
    logic         have_q;
    logic [W-1:0] last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            have_q <= 1'b0;
            last_q <= '0;
        end else if (clear_i) begin
            have_q <= 1'b0;
        end else if (|lane_start_o) begin
            have_q <= 1'b1;
            last_q <= ctr0;
        end
    end

    assert_strobe_all_or_none_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_start_o == '0) || (lane_start_o == '1));

    assert_strobe_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (|lane_start_o) |=> (lane_start_o == '0));

    assert_base_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (have_q && (|lane_start_o)) |-> (ctr0 == last_q + W'(LANES)));

    assert_room_before_launch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|lane_start_o) |-> (int'(occ) <= DEPTH - LANES));

    assert_primed_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (primed_o && !clear_i) |=> primed_o);

    assert_primed_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(primed_o) |-> ks_valid_o);

    assert_clear_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (!ks_valid_o && !primed_o));
endmodule

bind ctr_keystream_sched ksched_chk #(.LANES(LANES), .W(W), .DEPTH(DEPTH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .clear_i      (clear_i),
    .lane_start_o (lane_start_o),
    .ctr0         (lane_ctr_o[W-1:0]),
    .ks_valid_o   (ks_valid_o),
    .primed_o     (primed_o),
    .occ          (fifo_count)
);

// File: tb/sim_ctr_keystream_sched.sv
`timescale 1ns/1ps
module sim_ctr_keystream_sched;
    localparam int LANES = 26;
    localparam int W     = 128;
    localparam logic [W-1:0] KEYC = 128'h3c6e_f372_a54f_f53a_510e_527f_9b05_688c;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               start_i = 1'b0;
    logic [W-1:0]       seed_i = '0;
    logic               clear_i = 1'b0;
    logic [LANES-1:0]   lane_start_o;
    logic [LANES*W-1:0] lane_ctr_o;
    logic [LANES-1:0]   lane_done = '0;
    logic [LANES*W-1:0] lane_data = '0;
    logic               ks_rd_i = 1'b0;
    logic [W-1:0]       ks_data_o;
    logic               ks_valid_o;
    logic               primed_o;

    int n_chk = 0, n_fail = 0, rounds = 0;
    bit ended = 0;
    logic [W-1:0] exp_base = '0;

    always #5 clk = ~clk;

    ctr_keystream_sched #(.LANES(LANES), .W(W), .DEPTH(32)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .seed_i(seed_i),
        .clear_i(clear_i), .lane_start_o(lane_start_o), .lane_ctr_o(lane_ctr_o),
        .lane_done_i(lane_done), .lane_data_i(lane_data), .ks_rd_i(ks_rd_i),
        .ks_data_o(ks_data_o), .ks_valid_o(ks_valid_o), .primed_o(primed_o)
    );

    function automatic logic [W-1:0] perm(input logic [W-1:0] x);
        return {x[114:0], x[127:115]} ^ KEYC;
    endfunction

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    // Lane models: random latency 1..8, result = perm(counter)
    logic [W-1:0] lctr [LANES];
    int           lcnt [LANES];
    always @(negedge clk) begin
        if (rst_n) begin
            if (|lane_start_o) begin
                logic ok;
                ok = 1'b1;
                for (int k = 0; k < LANES; k++)
                    if (lane_ctr_o[k*W +: W] !== exp_base + W'(k)) ok = 1'b0;
                // R2 / R4: each lane counter is round base + lane offset
                chk("R2_R4 lane counters", {127'd0, ok}, 128'd1);
                chk("R3 all lanes strobed", {{(W-LANES){1'b0}}, lane_start_o}, {{(W-LANES){1'b0}}, {LANES{1'b1}}});
                exp_base = exp_base + W'(LANES);
                rounds++;
            end
            for (int k = 0; k < LANES; k++) begin
                lane_done[k] = 1'b0;
                if (lcnt[k] > 0) begin
                    lcnt[k]--;
                    if (lcnt[k] == 0) begin
                        lane_done[k] = 1'b1;
                        lane_data[k*W +: W] = perm(lctr[k]);
                    end
                end
                if (lane_start_o[k]) begin
                    lctr[k] = lane_ctr_o[k*W +: W];
                    lcnt[k] = 1 + int'($urandom % 8);
                end
            end
        end
    end

    task automatic session_start(input logic [W-1:0] s);
        @(negedge clk);
        seed_i = s; start_i = 1'b1; exp_base = s;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_primed();
        int t;
        t = 0;
        while (!primed_o && t < 2000) begin @(negedge clk); t++; end
        chk("R6 primed after first round", {127'd0, primed_o}, 128'd1);
        chk("R6 queue valid when primed", {127'd0, ks_valid_o}, 128'd1);
    endtask

    task automatic read_words(input logic [W-1:0] s, input int n, input logic [W-1:0] alt);
        int idx;
        idx = 0;
        while (idx < n) begin
            @(negedge clk);
            ks_rd_i = 1'b0;
            if (idx == 5) begin seed_i = alt; start_i = 1'b1; end   // R10 start mid-session
            else start_i = 1'b0;
            if (ks_valid_o && ($urandom % 4 != 0)) begin
                chk("R5_R8 keystream order", ks_data_o, perm(s + W'(idx)));
                idx++;
                ks_rd_i = 1'b1;
            end
        end
        @(negedge clk);
        ks_rd_i = 1'b0;
        start_i = 1'b0;
    endtask

    initial begin
        logic [W-1:0] sa, sb;
        void'($urandom(32'h1d2c_3b4a));
        for (int k = 0; k < LANES; k++) lcnt[k] = 0;
        sa = {$urandom, $urandom, $urandom, $urandom};
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 strobes idle", {{(W-LANES){1'b0}}, lane_start_o}, '0);
        chk("R1 queue empty", {127'd0, ks_valid_o}, '0);
        chk("R1 not primed", {127'd0, primed_o}, '0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        session_start(sa);
        wait_primed();
        repeat (100) @(negedge clk);
        chk("R7 single round without reads", W'(rounds), W'(1));

        read_words(sa, 200, ~sa);
        chk("R7 refills triggered by reads", {127'd0, rounds > 7}, 128'd1);

        // clear at a random point while rounds may be in flight
        repeat ($urandom % 6) @(negedge clk);
        clear_i = 1'b1;
        @(negedge clk);
        clear_i = 1'b0;
        chk("R9 queue flushed", {127'd0, ks_valid_o}, '0);
        chk("R9 primed dropped", {127'd0, primed_o}, '0);
        // R8 reads on empty queue have no effect
        ks_rd_i = 1'b1;
        repeat (5) @(negedge clk);
        ks_rd_i = 1'b0;
        repeat (20) @(negedge clk);
        chk("R9 late done ignored", {127'd0, ks_valid_o}, '0);

        // second session near counter wrap
        sb = {128{1'b1}} - W'(9);
        session_start(sb);
        wait_primed();
        read_words(sb, 80, sa);

        clear_i = 1'b1;
        @(negedge clk);
        clear_i = 1'b0;
        chk("R9 flushed at end", {127'd0, ks_valid_o}, '0);
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule